// File: doc/BRIEF.md
# Load-Store Data Alignment Unit

This unit sits between a 32-bit integer pipeline and a 32-bit big-endian data memory port. For each accepted request it forms the effective address from a base register plus either a second register or a sign-extended 13-bit immediate. It checks that address against the natural alignment of the access size.

For a load, it picks the addressed byte lanes out of the returned memory word and hands back a right-justified register value, either sign-extended or zero-filled. For a store, it copies the register data into every lane of the width and raises only the byte enables of the addressed bytes.

A doubleword access is split into two word transfers on consecutive cycles. The first transfer goes to the even register of a pair and the second to the following odd register. A misaligned request produces a one-cycle fault pulse and has no other effect.

Top module: `lsu_align`

## Requirements
- R1: The effective address is `rs1_i + rs2_i` when `use_imm_i` is 0, and `rs1_i + sign_extend(imm_i)` when it is 1. `mem_addr_o` carries that address with its two low bits cleared.
- R2: `size_i` encodes 0 = byte, 1 = halfword, 2 = word, 3 = doubleword. A halfword needs address bit 0 clear, a word needs bits 1:0 clear, and a doubleword needs bits 2:0 clear. A misaligned request gives `fault_o` high for exactly the next cycle, with no `mem_req_o` in the request cycle and no writeback.
- R3: A signed byte or halfword load (`signed_i` = 1) returns the datum in the low bits and copies its top bit into every upper bit.
- R4: An unsigned byte or halfword load fills every bit above the datum with zero.
- R5: Lanes are big-endian. The byte at offset k of a word is `mem_rdata_i[31-8k -: 8]`. The halfword at offset 0 is bits 31:16 and the one at offset 2 is bits 15:0.
- R6: Bit 3 of `mem_be_o` selects offset 0 and bit 0 selects offset 3. A byte store enables one lane, a halfword store enables 1100 or 0011, and a word store enables 1111. The data is replicated across `mem_wdata_o`, so bytes outside the enabled lanes stay unchanged in memory.
- R7: A word load returns the whole memory word unchanged, whatever the value of `signed_i`.
- R8: A doubleword access issues a word transfer at address A in the request cycle and another at A+4 in the next cycle. `busy_o` is high during that second cycle. The first word belongs to the even register `{rd_i[4:1],0}` (store data `st_data_i`) and the second to the odd register `{rd_i[4:1],1}` (store data `st_data2_i`).
- R9: A request presented while `busy_o` is high is ignored.
- R10: A load writes back one cycle after its transfer, with `wb_valid_o`, `wb_reg_o` and `wb_data_o`. A store never produces a writeback.
- R11: While reset is held and after it is released, with no request, `mem_req_o`, `wb_valid_o`, `fault_o` and `busy_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = store, 0 = load |
| size_i | input | 2 | Access size (0 byte, 1 half, 2 word, 3 doubleword) |
| signed_i | input | 1 | Sign-extend byte/half loads |
| rs1_i | input | 32 | Base register value |
| rs2_i | input | 32 | Index register value |
| imm_i | input | 13 | Immediate offset, two's complement |
| use_imm_i | input | 1 | Select immediate instead of index register |
| rd_i | input | 5 | Destination register index |
| st_data_i | input | 32 | Store data (even register for doubleword) |
| st_data2_i | input | 32 | Store data of the odd register for doubleword |
| busy_o | output | 1 | Second doubleword transfer in progress |
| fault_o | output | 1 | Alignment fault pulse |
| mem_req_o | output | 1 | Memory transfer valid |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | 32 | Word-aligned memory address |
| mem_be_o | output | 4 | Byte enables, bit 3 = offset 0 |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid in the transfer cycle |
| wb_valid_o | output | 1 | Register writeback valid |
| wb_reg_o | output | 5 | Writeback register index |
| wb_data_o | output | 32 | Writeback value |

## Verification
Most internal faults in this unit show up at the ports within two cycles.

- A wrong lane offset or extension rule gives a bad `wb_data_o` one cycle after the transfer.
- A wrong enable decode corrupts the neighbouring bytes, which a later word read exposes.
- A lost or spurious doubleword pending flag shows up in the following cycle as a missing or extra transfer at A+4, a stuck `busy_o`, or a swapped `wb_reg_o`.
- A broken alignment check either lets a transfer reach memory or fails to raise `fault_o` on the next edge.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
  localparam int DATA_W = 32;
  localparam int BYTES  = DATA_W / 8;
  localparam int OFF_W  = $clog2(BYTES);

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } acc_size_e;
endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
  import lsu_align_pkg::*;
#(
  parameter int AW    = 32,
  parameter int IMM_W = 13
) (
  input  logic [AW-1:0]    rs1_i,
  input  logic [AW-1:0]    rs2_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             use_imm_i,
  input  acc_size_e        size_i,
  output logic [AW-1:0]    addr_o,
  output logic             misal_o
);
  logic [AW-1:0] offs;

  assign offs   = use_imm_i ? {{(AW-IMM_W){imm_i[IMM_W-1]}}, imm_i} : rs2_i;
  assign addr_o = rs1_i + offs;

  always_comb begin
    unique case (size_i)
      SZ_BYTE:  misal_o = 1'b0;
      SZ_HALF:  misal_o = addr_o[0];
      SZ_WORD:  misal_o = |addr_o[1:0];
      default:  misal_o = |addr_o[2:0];
    endcase
  end
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane
  import lsu_align_pkg::*;
(
  input  acc_size_e          size_i,
  input  logic [OFF_W-1:0]   off_i,
  input  logic [DATA_W-1:0]  data_i,
  output logic [BYTES-1:0]   be_o,
  output logic [DATA_W-1:0]  wdata_o
);
  localparam logic [BYTES-1:0] BE_TOP = {1'b1, {(BYTES-1){1'b0}}};
  localparam logic [BYTES-1:0] HALF_HI = {{(BYTES/2){1'b1}}, {(BYTES/2){1'b0}}};

  always_comb begin
    unique case (size_i)
      SZ_BYTE: begin
        be_o    = BE_TOP >> off_i;
        wdata_o = {BYTES{data_i[7:0]}};
      end
      SZ_HALF: begin
        be_o    = off_i[OFF_W-1] ? ~HALF_HI : HALF_HI;
        wdata_o = {(BYTES/2){data_i[15:0]}};
      end
      default: begin
        be_o    = '1;
        wdata_o = data_i;
      end
    endcase
  end
endmodule

// File: rtl/lsu_load_lane.sv
module lsu_load_lane
  import lsu_align_pkg::*;
(
  input  acc_size_e          size_i,
  input  logic [OFF_W-1:0]   off_i,
  input  logic               signed_i,
  input  logic [DATA_W-1:0]  rdata_i,
  output logic [DATA_W-1:0]  value_o
);
  logic [7:0]  byte_sel;
  logic [15:0] half_sel;

  // lowest offset holds the most significant lane
  assign byte_sel = rdata_i[8*(BYTES-1-int'(off_i)) +: 8];
  assign half_sel = off_i[OFF_W-1] ? rdata_i[15:0] : rdata_i[DATA_W-1 -: 16];

  always_comb begin
    unique case (size_i)
      SZ_BYTE: value_o = {{(DATA_W-8){signed_i & byte_sel[7]}}, byte_sel};
      SZ_HALF: value_o = {{(DATA_W-16){signed_i & half_sel[15]}}, half_sel};
      default: value_o = rdata_i;
    endcase
  end
endmodule

// File: rtl/lsu_align.sv
module lsu_align
  import lsu_align_pkg::*;
#(
  parameter int AW     = 32,
  parameter int IMM_W  = 13,
  parameter int RIDX_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        size_i,
  input  logic              signed_i,
  input  logic [AW-1:0]     rs1_i,
  input  logic [AW-1:0]     rs2_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              use_imm_i,
  input  logic [RIDX_W-1:0] rd_i,
  input  logic [DATA_W-1:0] st_data_i,
  input  logic [DATA_W-1:0] st_data2_i,
  output logic              busy_o,
  output logic              fault_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [BYTES-1:0]  mem_be_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              wb_valid_o,
  output logic [RIDX_W-1:0] wb_reg_o,
  output logic [DATA_W-1:0] wb_data_o
);
  localparam logic [AW-1:0] WORD_STEP = AW'(BYTES);

  acc_size_e         req_size, lane_size;
  logic [AW-1:0]     eff_addr, word_addr;
  logic              misal, accept, go;
  logic [OFF_W-1:0]  lane_off;
  logic [DATA_W-1:0] lane_src, st_wdata, ld_value;
  logic [BYTES-1:0]  st_be;
  logic [RIDX_W-1:0] cur_rd, pair_even;

  logic              pend_q, pend_we_q;
  logic [AW-1:0]     pend_addr_q;
  logic [DATA_W-1:0] pend_data_q;
  logic [RIDX_W-1:0] pend_rd_q;
  logic              fault_q, wb_valid_q;
  logic [RIDX_W-1:0] wb_reg_q;
  logic [DATA_W-1:0] wb_data_q;

  assign req_size = acc_size_e'(size_i);

  lsu_agen #(.AW(AW), .IMM_W(IMM_W)) u_agen (
    .rs1_i     (rs1_i),
    .rs2_i     (rs2_i),
    .imm_i     (imm_i),
    .use_imm_i (use_imm_i),
    .size_i    (req_size),
    .addr_o    (eff_addr),
    .misal_o   (misal)
  );

  assign busy_o    = pend_q;
  assign accept    = req_i && !pend_q;
  assign go        = accept && !misal;
  assign word_addr = {eff_addr[AW-1:OFF_W], {OFF_W{1'b0}}};
  assign pair_even = {rd_i[RIDX_W-1:1], 1'b0};

  // second doubleword beat overrides the request path
  always_comb begin
    if (pend_q) begin
      lane_size   = SZ_WORD;
      lane_off    = '0;
      lane_src    = pend_data_q;
      mem_we_o    = pend_we_q;
      mem_addr_o  = pend_addr_q;
      cur_rd      = pend_rd_q;
    end else begin
      lane_size   = (req_size == SZ_DWORD) ? SZ_WORD : req_size;
      lane_off    = eff_addr[OFF_W-1:0];
      lane_src    = st_data_i;
      mem_we_o    = we_i;
      mem_addr_o  = word_addr;
      cur_rd      = (req_size == SZ_DWORD) ? pair_even : rd_i;
    end
  end

  assign mem_req_o = go || pend_q;

  lsu_store_lane u_st (
    .size_i  (lane_size),
    .off_i   (lane_off),
    .data_i  (lane_src),
    .be_o    (st_be),
    .wdata_o (st_wdata)
  );

  lsu_load_lane u_ld (
    .size_i   (lane_size),
    .off_i    (lane_off),
    .signed_i (signed_i && !pend_q),
    .rdata_i  (mem_rdata_i),
    .value_o  (ld_value)
  );

  assign mem_be_o    = mem_req_o ? st_be : '0;
  assign mem_wdata_o = st_wdata;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      pend_we_q   <= 1'b0;
      pend_addr_q <= '0;
      pend_data_q <= '0;
      pend_rd_q   <= '0;
      fault_q     <= 1'b0;
      wb_valid_q  <= 1'b0;
      wb_reg_q    <= '0;
      wb_data_q   <= '0;
    end else begin
      pend_q     <= go && (req_size == SZ_DWORD);
      fault_q    <= accept && misal;
      wb_valid_q <= mem_req_o && !mem_we_o;
      if (go && (req_size == SZ_DWORD)) begin
        pend_we_q   <= we_i;
        pend_addr_q <= word_addr + WORD_STEP;
        pend_data_q <= st_data2_i;
        pend_rd_q   <= {rd_i[RIDX_W-1:1], 1'b1};
      end
      if (mem_req_o && !mem_we_o) begin
        wb_reg_q  <= cur_rd;
        wb_data_q <= ld_value;
      end
    end
  end

  assign fault_o    = fault_q;
  assign wb_valid_o = wb_valid_q;
  assign wb_reg_o   = wb_reg_q;
  assign wb_data_o  = wb_data_q;

  p_fault_nowb_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !wb_valid_o);

  p_fault_noreq_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> $past(!mem_req_o));

  p_be_shape_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |->
      ($countones(mem_be_o) == 1 || $countones(mem_be_o) == 2 || $countones(mem_be_o) == BYTES));

  p_dword_next_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (mem_req_o && mem_addr_o == $past(mem_addr_o) + WORD_STEP));

  p_busy_once_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !busy_o);

  p_wb_follows_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> $past(mem_req_o && !mem_we_o));
endmodule

// File: tb/lsu_align_tb.sv
module lsu_align_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        req, we, sgn, use_imm;
  logic [1:0]  size;
  logic [31:0] rs1, rs2, sd, sd2;
  logic [12:0] imm;
  logic [4:0]  rd;
  logic        busy, fault, mreq, mwe, wbv;
  logic [31:0] maddr, mwdata, mrdata, wbd;
  logic [3:0]  mbe;
  logic [4:0]  wbr;

  lsu_align u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .size_i(size),
    .signed_i(sgn), .rs1_i(rs1), .rs2_i(rs2), .imm_i(imm), .use_imm_i(use_imm),
    .rd_i(rd), .st_data_i(sd), .st_data2_i(sd2), .busy_o(busy), .fault_o(fault),
    .mem_req_o(mreq), .mem_we_o(mwe), .mem_addr_o(maddr), .mem_be_o(mbe),
    .mem_wdata_o(mwdata), .mem_rdata_i(mrdata), .wb_valid_o(wbv),
    .wb_reg_o(wbr), .wb_data_o(wbd)
  );

  logic [31:0] mem [16];
  assign mrdata = mem[maddr[5:2]];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= 32'h0;
      mem[1] <= 32'h8A7F_C312;
      mem[2] <= 32'h1234_5678;
      mem[3] <= 32'h9ABC_DEF0;
    end else if (mreq && mwe) begin
      for (int b = 0; b < 4; b++)
        if (mbe[b]) mem[maddr[5:2]][8*b +: 8] <= mwdata[8*b +: 8];
    end
  end

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // captured port values, cycle 0 (request), 1 and 2
  logic        c0_req, c1_req, c2_req, c1_busy, c2_busy, c1_fault, c2_fault;
  logic        c1_wbv, c2_wbv;
  logic [31:0] c0_addr, c1_addr, c0_wd, c1_wd, c1_wbd, c2_wbd;
  logic [3:0]  c0_be;
  logic [4:0]  c1_wbr, c2_wbr;

  task automatic op(input logic w, input logic [1:0] s, input logic g,
                    input logic ui, input logic [31:0] a, input logic [31:0] o,
                    input logic [4:0] r, input logic [31:0] d, input logic [31:0] d2,
                    input bit hold);
    @(negedge clk);
    req = 1'b1; we = w; size = s; sgn = g; use_imm = ui; rs1 = a;
    rs2 = o; imm = o[12:0]; rd = r; sd = d; sd2 = d2;
    #1;
    c0_req = mreq; c0_addr = maddr; c0_be = mbe; c0_wd = mwdata;
    @(negedge clk);
    if (!hold) req = 1'b0;
    #1;
    c1_req = mreq; c1_busy = busy; c1_fault = fault; c1_addr = maddr;
    c1_wd = mwdata; c1_wbv = wbv; c1_wbd = wbd; c1_wbr = wbr;
    @(negedge clk);
    req = 1'b0;
    #1;
    c2_req = mreq; c2_busy = busy; c2_fault = fault;
    c2_wbv = wbv; c2_wbd = wbd; c2_wbr = wbr;
  endtask

  task automatic rd_word(input logic [31:0] a, output logic [31:0] v);
    op(1'b0, 2'd2, 1'b0, 1'b0, a, 32'h0, 5'd1, 32'h0, 32'h0, 1'b0);
    v = c1_wbd;
  endtask

  // {size, signed, use_imm, rs1, offset, expected}
  localparam logic [99:0] VEC [NVEC] = '{
    {2'd0, 1'b1, 1'b0, 32'd4,  32'd0,        32'hFFFF_FF8A},
    {2'd0, 1'b0, 1'b0, 32'd4,  32'd0,        32'h0000_008A},
    {2'd0, 1'b1, 1'b0, 32'd3,  32'd2,        32'h0000_007F},
    {2'd0, 1'b1, 1'b1, 32'd10, 32'h0000_1FFC, 32'hFFFF_FFC3},
    {2'd0, 1'b0, 1'b0, 32'd7,  32'd0,        32'h0000_0012},
    {2'd1, 1'b1, 1'b1, 32'd10, 32'h0000_1FFA, 32'hFFFF_8A7F},
    {2'd1, 1'b0, 1'b0, 32'd6,  32'd0,        32'h0000_C312},
    {2'd1, 1'b1, 1'b0, 32'd2,  32'd4,        32'hFFFF_C312},
    {2'd2, 1'b1, 1'b0, 32'd8,  32'd0,        32'h1234_5678},
    {2'd2, 1'b1, 1'b1, 32'd0,  32'h0000_0004, 32'h8A7F_C312}
  };

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    req = 0; we = 0; size = 0; sgn = 0; use_imm = 0;
    rs1 = 0; rs2 = 0; imm = 0; rd = 0; sd = 0; sd2 = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 mem_req in reset", {31'h0, mreq}, 32'h0);
    chk("R11 busy in reset", {31'h0, busy}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R11 idle outputs", {28'h0, mreq, wbv, fault, busy}, 32'h0);

    // R1 R3 R4 R5 R7 R10: load table
    for (int i = 0; i < NVEC; i++) begin
      op(1'b0, VEC[i][99:98], VEC[i][97], VEC[i][96], VEC[i][95:64], VEC[i][63:32],
         5'd9, 32'h0, 32'h0, 1'b0);
      chk($sformatf("R3/R4/R5/R7 load value vec %0d", i), c1_wbd, VEC[i][31:0]);
      chk("R10 wb valid after load", {31'h0, c1_wbv}, 32'h1);
      chk("R10 wb reg", {27'h0, c1_wbr}, 32'd9);
      chk("R1 word address", c0_addr,
          {(VEC[i][95:64] + (VEC[i][96] ? {{19{VEC[i][44]}}, VEC[i][44:32]} : VEC[i][63:32])) & 32'hFFFF_FFFC});
    end

    // R6 byte store offset 1, no writeback
    op(1'b1, 2'd0, 1'b0, 1'b0, 32'd13, 32'd0, 5'd3, 32'h0000_00AB, 32'h0, 1'b0);
    chk("R6 byte enable offset1", {28'h0, c0_be}, 32'h4);
    chk("R6 byte replicated", c0_wd, 32'hABAB_ABAB);
    chk("R10 no wb on store", {31'h0, c1_wbv}, 32'h0);
    rd_word(32'd12, v);
    chk("R6 byte store lanes", v, 32'h9AAB_DEF0);

    // R6 half store offset 2
    op(1'b1, 2'd1, 1'b1, 1'b0, 32'd14, 32'd0, 5'd3, 32'h5555_BEEF, 32'h0, 1'b0);
    chk("R6 half enable offset2", {28'h0, c0_be}, 32'h3);
    rd_word(32'd12, v);
    chk("R6 half store lanes", v, 32'h9AAB_BEEF);

    // R2 misaligned half load
    op(1'b0, 2'd1, 1'b1, 1'b0, 32'd5, 32'd0, 5'd2, 32'h0, 32'h0, 1'b0);
    chk("R2 no mem req on misalign", {31'h0, c0_req}, 32'h0);
    chk("R2 fault pulse", {30'h0, c1_fault, c2_fault}, 32'h2);
    chk("R2 no wb on fault", {30'h0, c1_wbv, c2_wbv}, 32'h0);

    // R2 misaligned word store leaves memory unchanged
    op(1'b1, 2'd2, 1'b0, 1'b0, 32'd10, 32'd0, 5'd2, 32'hDEAD_BEEF, 32'h0, 1'b0);
    chk("R2 word store misalign fault", {31'h0, c1_fault}, 32'h1);
    rd_word(32'd8, v);
    chk("R2 memory untouched", v, 32'h1234_5678);

    // R2 dword at address 4
    op(1'b0, 2'd3, 1'b0, 1'b0, 32'd4, 32'd0, 5'd6, 32'h0, 32'h0, 1'b0);
    chk("R2 dword misalign", {29'h0, c0_req, c1_fault, c1_busy}, 32'h2);

    // R8 R9 dword load, odd rd, request held into busy cycle
    op(1'b0, 2'd3, 1'b0, 1'b0, 32'd8, 32'd0, 5'd7, 32'h0, 32'h0, 1'b1);
    chk("R8 first addr", c0_addr, 32'd8);
    chk("R8 second addr busy", {c1_addr[30:0], c1_busy}, {31'd12, 1'b1});
    chk("R8 even reg first", {c1_wbd[26:0], c1_wbr}, {32'h1234_5678 << 5 | 32'd6});
    chk("R8 odd data", c2_wbd, 32'h9AAB_BEEF);
    chk("R8 odd reg", {27'h0, c2_wbr}, 32'd7);
    chk("R9 held request ignored", {30'h0, c2_req, c2_busy}, 32'h0);

    // R8 dword store
    op(1'b1, 2'd3, 1'b0, 1'b1, 32'd16, 32'h0000_1FF0, 5'd4, 32'h1111_2222, 32'h3333_4444, 1'b0);
    chk("R8 store first data", c0_wd, 32'h1111_2222);
    chk("R8 store second data", c1_wd, 32'h3333_4444);
    rd_word(32'd0, v);
    chk("R8 even word low addr", v, 32'h1111_2222);
    rd_word(32'd4, v);
    chk("R8 odd word high addr", v, 32'h3333_4444);

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule